// File: doc/BRIEF.md
# Receive FIFO Reset Sequencer

This block sits beside a receive FIFO and runs its reset on the receive clock. The host asks for a reset by pulling an active-low request low while the interface select is low and the read enable is held high. Once that combination has held for eight consecutive clock edges, the sequencer enters a pending state. In that state the FIFO flags read as Empty, reads cannot happen and writes from the fill side are dropped. The pending state lasts until the host removes either the request or the select. At that edge both pointers and the occupancy return to zero.

No separate completion signal exists. The FIFO becomes usable again when the fill side writes the next word, and that write clears Empty.

When the reset ends because the request input rises, read selection is blocked for the next clock cycle. A read enable that is low during that blocked cycle stays ignored until it goes high and then low again. The block also keeps the read and write pointers, the occupancy count and the Empty, Half and Full flags for the FIFO storage, which sits outside it.

Top module: `rx_fifo_rst_seq`

## Requirements
- R1: After a synchronous system reset (rst_n low at a clock edge), the outputs are as follows: empty_n = 0, half_n = 1, full_n = 1, wr_addr = 0 and rd_addr = 0. With en_n high, sel_active = 0.
- R2: A reset is recognised when rst_req_n = 0, sel_n = 0 and en_n = 1 are sampled together at eight consecutive edges. After the eighth edge the flags read Empty (empty_n = 0, half_n = 1, full_n = 1), whatever the occupancy.
- R3: If any of the three conditions fails at an edge before the eighth, the qualification count starts again from zero. A later run then needs a full eight edges.
- R4: While a reset is pending, wr_req is not accepted (wr_ack = 0) and no read takes place (rd_ack = 0, sel_active = 0), even with en_n low.
- R5: A pending reset ends only at an edge where rst_req_n or sel_n is sampled high. At that edge wr_addr, rd_addr and the occupancy return to zero.
- R6: After the reset ends, empty_n stays 0 until the first write is accepted. empty_n reads 1 after the edge that accepts that write.
- R7: If the reset ends through rst_req_n rising, sel_active is 0 for the whole next cycle, even with en_n and sel_n low.
- R8: If en_n is low during that blocked cycle, sel_active stays 0 for as long as en_n stays low. It becomes 1 only after en_n has been sampled high and is then driven low again.
- R9: If the reset ends through sel_n rising while rst_req_n is still low, no cycle is blocked. In the next cycle, sel_n = 0 with en_n = 0 gives sel_active = 1 at once.
- R10: Outside a pending reset, a write is accepted when occupancy is below DEPTH, and a read takes place when sel_active = 1 and occupancy is above zero. half_n = 0 when occupancy is at least DEPTH/2. full_n = 0 when occupancy equals DEPTH, and at that point wr_ack = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| rst_req_n | input | 1 | Active-low FIFO reset request from the host |
| sel_n | input | 1 | Active-low interface select |
| en_n | input | 1 | Active-low read enable (selection for transfers) |
| wr_req | input | 1 | Fill-side write request |
| wr_ack | output | 1 | Write accepted at the coming edge |
| rd_ack | output | 1 | Read takes place at the coming edge |
| sel_active | output | 1 | Interface currently selected for reading |
| wr_addr | output | AW | Write pointer into the FIFO storage |
| rd_addr | output | AW | Read pointer into the FIFO storage |
| empty_n | output | 1 | Active-low Empty flag |
| half_n | output | 1 | Active-low half-full flag |
| full_n | output | 1 | Active-low Full flag |

## Verification
The flags and pointers are registered, so their new values appear one edge after the sampled stimulus. The bench applies inputs on the falling edge and checks them on the following falling edge. Reset recognition appears after the eighth qualifying edge, and the bench counts exactly eight steps before it looks at the flags. sel_active, wr_ack and rd_ack combine the current inputs with registered state, so they are checked one nanosecond after the inputs change, inside the same cycle. That covers the blocked cycle just after release and the same-cycle selection when no cycle is blocked.

// File: rtl/rx_fifo_rst_pkg.sv
// Shared types for the receive FIFO reset sequencer.
// Assumes nothing beyond a single receive clock domain.
package rx_fifo_rst_pkg;
    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_HOLD = 1'b1
    } rst_phase_t;
endpackage

// File: rtl/rx_rst_qual.sv
// Qualification counter and reset phase tracker.
// Counts consecutive edges at which the reset request is qualified and enters
// the pending phase after QUAL_CYCLES of them. Leaves the pending phase when
// the request or the select is sampled released.
// Assumes QUAL_CYCLES >= 2.
module rx_rst_qual
    import rx_fifo_rst_pkg::*;
#(
    parameter int QUAL_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    input  logic req_off,
    input  logic sel_off,
    output logic hold,
    output logic clear,
    output logic lock_arm
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);

    rst_phase_t    phase;
    logic [CW-1:0] cnt;

    // Advance the qualification count and the reset phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_RUN;
            cnt   <= '0;
        end else if (phase == PH_RUN) begin
            if (!qual) begin
                cnt <= '0;
            end else if (cnt == CW'(QUAL_CYCLES - 1)) begin
                cnt   <= '0;
                phase <= PH_HOLD;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (req_off || sel_off) begin
            phase <= PH_RUN;
        end
    end

    // Decode phase outputs and the release event.
    always_comb begin
        hold     = (phase == PH_HOLD);
        clear    = hold && (req_off || sel_off);
        lock_arm = hold && req_off;
    end

    // R3: a broken qualification run restarts from zero.
    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN && !qual) |=> (cnt == '0));

    // R2: the pending phase is entered only from a qualified edge.
    a_r2_entry_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(qual));
endmodule

// File: rtl/rx_sel_gate.sv
// Read-selection gate.
// Blocks selection for one cycle after a release through the request input,
// and keeps blocking while the enable is held low from that cycle onward.
// Assumes en_n and sel_n are synchronous to clk.
module rx_sel_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_arm,
    input  logic hold,
    input  logic en_n,
    input  logic sel_n,
    output logic sel_active
);
    logic lock;
    logic stuck;

    // Track the blocked cycle and a selection attempt made during it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock  <= 1'b0;
            stuck <= 1'b0;
        end else begin
            lock <= lock_arm;
            if (lock && !en_n) begin
                stuck <= 1'b1;
            end else if (en_n) begin
                stuck <= 1'b0;
            end
        end
    end

    // Selection is granted only outside every blocking condition.
    always_comb begin
        sel_active = !en_n && !sel_n && !hold && !lock && !stuck;
    end

    // R8: an enable held low straight through the blocked cycle stays unselected.
    a_r8_no_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock) && $past(!en_n) && !en_n) |-> !sel_active);
endmodule

// File: rtl/rx_fifo_ptrs.sv
// FIFO pointer, occupancy and flag keeper.
// Storage lives outside; this module issues addresses and acknowledges.
// Flags are forced to Empty while a reset is pending. Assumes DEPTH is a
// power of two so the pointers wrap naturally.
module rx_fifo_ptrs #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          clear,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_ack,
    output logic          rd_ack,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          empty_n,
    output logic          half_n,
    output logic          full_n
);
    localparam int OW = $clog2(DEPTH + 1);
    localparam logic [OW-1:0] OCC_FULL = OW'(DEPTH);
    localparam logic [OW-1:0] OCC_HALF = OW'(DEPTH / 2);

    logic [OW-1:0] occ;

    // Decide which transfers take place at the coming edge.
    always_comb begin
        wr_ack = wr_req && !hold && (occ != OCC_FULL);
        rd_ack = rd_req && !hold && (occ != '0);
    end

    // Move pointers and occupancy; a release clears all of them.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_addr <= '0;
            rd_addr <= '0;
            occ     <= '0;
        end else begin
            if (wr_ack) wr_addr <= wr_addr + 1'b1;
            if (rd_ack) rd_addr <= rd_addr + 1'b1;
            if (wr_ack && !rd_ack) occ <= occ + 1'b1;
            else if (rd_ack && !wr_ack) occ <= occ - 1'b1;
        end
    end

    // Drive the active-low flags, forced to Empty while pending.
    always_comb begin
        empty_n = !(hold || (occ == '0));
        half_n  = !(!hold && (occ >= OCC_HALF));
        full_n  = !(!hold && (occ == OCC_FULL));
    end

    // R4: no write moves the write pointer while a reset is pending.
    a_r4_no_write_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clear) |=> $stable(wr_addr));

    // R5: both pointers are zero right after a release.
    a_r5_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> (wr_addr == '0 && rd_addr == '0));

    // R10: a full FIFO stays full until something is read.
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_FULL && !rd_ack && !clear) |=> (occ == OCC_FULL));
endmodule

// File: rtl/rx_fifo_rst_seq.sv
// Receive FIFO reset sequencer, top level.
// Qualifies a host reset request, holds the FIFO flagged Empty while the
// request is pending, clears the pointers on release and gates re-selection.
// Assumes all inputs are synchronous to clk.
module rx_fifo_rst_seq #(
    parameter int DEPTH       = 16,
    parameter int QUAL_CYCLES = 8,
    parameter int AW          = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_req_n,
    input  logic          sel_n,
    input  logic          en_n,
    input  logic          wr_req,
    output logic          wr_ack,
    output logic          rd_ack,
    output logic          sel_active,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          empty_n,
    output logic          half_n,
    output logic          full_n
);
    logic qual;
    logic hold;
    logic clear;
    logic lock_arm;

    // Reset request qualifies with select low and no read enable.
    always_comb begin
        qual = !rst_req_n && !sel_n && en_n;
    end

    rx_rst_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual     (qual),
        .req_off  (rst_req_n),
        .sel_off  (sel_n),
        .hold     (hold),
        .clear    (clear),
        .lock_arm (lock_arm)
    );

    rx_sel_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_arm   (lock_arm),
        .hold       (hold),
        .en_n       (en_n),
        .sel_n      (sel_n),
        .sel_active (sel_active)
    );

    rx_fifo_ptrs #(.DEPTH(DEPTH), .AW(AW)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .clear   (clear),
        .wr_req  (wr_req),
        .rd_req  (sel_active),
        .wr_ack  (wr_ack),
        .rd_ack  (rd_ack),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .empty_n (empty_n),
        .half_n  (half_n),
        .full_n  (full_n)
    );

    // R7: the cycle after a release through the request input is unselected.
    a_r7_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold) && $past(rst_req_n)) |-> !sel_active);
endmodule

// File: tb/test_rx_fifo_rst_seq.sv
`timescale 1ns/1ps
module test_rx_fifo_rst_seq;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    typedef struct packed {
        logic       rq;
        logic       sl;
        logic       en;
        logic       wr;
        logic       x_empty_n;
        logic       x_sel;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0, 4'd10}, // R10 first write clears Empty
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd3},  // R3 qualify edge 1
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd3},
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd3},
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd3},
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd3},
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd3},  // R3 qualify edge 6
        '{1'b0,1'b1,1'b1,1'b0, 1'b1,1'b0, 4'd3},  // R3 select dropped: restart
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd3},
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd3},
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd3},
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd3},
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd3},
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd3},
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd3},  // R3 seventh edge: not yet
        '{1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0, 4'd2},  // R2 eighth edge: forced Empty
        '{1'b0,1'b0,1'b1,1'b1, 1'b0,1'b0, 4'd4},  // R4 write dropped
        '{1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd7},  // R7 release, blocked cycle
        '{1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd8},  // R8 enable held low
        '{1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd8},
        '{1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0, 4'd8},  // R8 enable removed
        '{1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1, 4'd8},  // R8 enable reapplied
        '{1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0, 4'd6}   // R6 first write after reset
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rst_req_n, sel_n, en_n, wr_req;
    logic          wr_ack, rd_ack, sel_active;
    logic [AW-1:0] wr_addr, rd_addr;
    logic          empty_n, half_n, full_n;
    int            n_chk  = 0;
    int            n_fail = 0;

    always #2.5 clk = ~clk;

    rx_fifo_rst_seq #(.DEPTH(DEPTH)) i_rx_fifo_rst_seq (
        .clk(clk), .rst_n(rst_n), .rst_req_n(rst_req_n), .sel_n(sel_n),
        .en_n(en_n), .wr_req(wr_req), .wr_ack(wr_ack), .rd_ack(rd_ack),
        .sel_active(sel_active), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
    );

    task automatic check(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic rq, input logic sl, input logic en, input logic wr);
        rst_req_n = rq; sel_n = sl; en_n = en; wr_req = wr;
    endtask

    task automatic sys_reset();
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 1'b1, 1'b0);
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        sys_reset();
        // R1 reset state
        check("R1", "empty_n", int'(empty_n), 0);
        check("R1", "half_n", int'(half_n), 1);
        check("R1", "full_n", int'(full_n), 1);
        check("R1", "sel_active", int'(sel_active), 0);
        check("R1", "wr_addr", int'(wr_addr), 0);
        check("R1", "rd_addr", int'(rd_addr), 0);

        // Vector walk: each row checked after the edge that sampled it.
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].rq, TBL[i].sl, TBL[i].en, TBL[i].wr);
            step();
            check($sformatf("R%0d row %0d", TBL[i].req, i), "empty_n",
                  int'(empty_n), int'(TBL[i].x_empty_n));
            check($sformatf("R%0d row %0d", TBL[i].req, i), "sel_active",
                  int'(sel_active), int'(TBL[i].x_sel));
        end

        // R10 fill to full, half and full flags
        sys_reset();
        for (int k = 1; k <= DEPTH; k++) begin
            drive(1'b1, 1'b1, 1'b1, 1'b1);
            step();
            if (k == DEPTH/2 - 1) check("R10", "half_n below half", int'(half_n), 1);
            if (k == DEPTH/2)     check("R10", "half_n at half", int'(half_n), 0);
            if (k == DEPTH - 1)   check("R10", "full_n one short", int'(full_n), 1);
        end
        check("R10", "full_n at depth", int'(full_n), 0);
        #1;
        check("R10", "wr_ack when full", int'(wr_ack), 0);
        step();
        check("R10", "wr_addr wrapped", int'(wr_addr), 0);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        #1;
        check("R10", "rd_ack when selected", int'(rd_ack), 1);
        step();
        check("R10", "full_n after read", int'(full_n), 1);
        check("R10", "rd_addr after read", int'(rd_addr), 1);

        // R2 forced Empty with a nearly full FIFO
        drive(1'b0, 1'b0, 1'b1, 1'b0);
        repeat (8) step();
        check("R2", "empty_n forced", int'(empty_n), 0);
        check("R2", "half_n forced", int'(half_n), 1);
        check("R2", "full_n forced", int'(full_n), 1);

        // R4 enable low while pending neither reads nor releases
        drive(1'b0, 1'b0, 1'b0, 1'b1);
        #1;
        check("R4", "rd_ack pending", int'(rd_ack), 0);
        check("R4", "wr_ack pending", int'(wr_ack), 0);
        check("R4", "sel_active pending", int'(sel_active), 0);
        step();
        check("R5", "still pending with enable low", int'(empty_n), 0);
        check("R4", "wr_addr unchanged", int'(wr_addr), 0);

        // R5 release through select, pointers cleared
        drive(1'b0, 1'b1, 1'b1, 1'b0);
        step();
        check("R5", "wr_addr cleared", int'(wr_addr), 0);
        check("R5", "rd_addr cleared", int'(rd_addr), 0);
        check("R6", "empty after release", int'(empty_n), 0);

        // R9 no blocked cycle after a select release
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        #1;
        check("R9", "sel_active at once", int'(sel_active), 1);
        step();
        check("R9", "sel_active next cycle", int'(sel_active), 1);
        drive(1'b1, 1'b1, 1'b1, 1'b0);
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule